// File: doc/BRIEF.md
# Burst Differential Symbol Encoder

This block differentially encodes the symbol bits of a bursty transmit stream ahead of constellation mapping. Each accepted symbol leaves the block one clock later as the sum, modulo the constellation's phase count, of the incoming symbol and the differential field of the symbol sent just before it. For BPSK the field is one bit (modulo 2). For QPSK it is two bits (modulo 4). For 16QAM only the two quadrant bits are encoded and the two bits inside the quadrant go through unchanged.

The encoding enable comes either from a hardware pin or from a software-held control bit, chosen by a select input. The enable acts one symbol late: a symbol is encoded only if the enable was high when the previous symbol was accepted. This timing sets the reference for the first data symbol of a burst. If the enable rises together with the last preamble symbol, the first data symbol is encoded against that preamble symbol. If it rises together with the first data symbol, that symbol is sent against a zero reference. The enable may also change in the middle of a burst, so the preamble and the data can use different encodings.

Top module: `burst_diff_encoder`

## Requirements
- R1: After reset `sym_valid_o` is 0 and `sym_o` is 0, and the first symbol accepted after reset leaves unencoded.
- R2: `sym_valid_o` is high exactly in the clock after a clock in which `sym_valid_i` is high.
- R3: An accepted symbol is differentially encoded if, and only if, the selected enable was high at the previously accepted symbol. Otherwise it leaves as received, with the bits outside the mode's width forced to 0.
- R4: With `mod_sel_i` = 01 (QPSK), `sym_o[1:0]` = (`sym_i[1:0]` + reference) mod 4 and `sym_o[3:2]` = 0.
- R5: With `mod_sel_i` = 00 (BPSK), `sym_o[0]` = `sym_i[0]` XOR reference bit 0 and `sym_o[3:1]` = 0.
- R6: With `mod_sel_i` = 10 or 11 (16QAM), `sym_o[3:2]` = (`sym_i[3:2]` + reference) mod 4 and `sym_o[1:0]` = `sym_i[1:0]`.
- R7: If the enable rises on the last preamble symbol, the first data symbol is encoded against that preamble symbol. If it rises on the first data symbol, that symbol leaves unchanged, which is encoding against a zero reference.
- R8: The reference is the differential field of the last symbol sent: bit 0 for BPSK, bits 1:0 for QPSK and bits 3:2 for 16QAM. This holds whether or not that symbol was encoded.
- R9: With `en_src_i` = 1 the enable is `en_reg_i` and the pin is ignored. With `en_src_i` = 0 the enable is `en_pin_i` and the register bit is ignored.
- R10: If the enable falls on the last data symbol, that symbol is still encoded and the symbol after it leaves unencoded.
- R11: In clocks without `sym_valid_i`, `sym_o` holds its value. Enable changes in those clocks leave both the reference and the enable history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid_i | input | 1 | Input symbol is present this clock |
| sym_i | input | SYM_W | Input symbol bits |
| mod_sel_i | input | 2 | Modulation: 00 BPSK, 01 QPSK, 1x 16QAM |
| en_pin_i | input | 1 | Hardware encoding enable |
| en_reg_i | input | 1 | Software encoding enable bit |
| en_src_i | input | 1 | Enable source: 1 software bit, 0 pin |
| sym_o | output | SYM_W | Encoded symbol |
| sym_valid_o | output | 1 | Encoded symbol is present this clock |

## Verification
The hardest case to reach from the ports is the start of a burst. There, the edge of the enable relative to the preamble and data symbols decides the reference, and a mistimed edge still produces plausible output. Directed bursts place the rising edge on the last preamble symbol in one case and on the first data symbol in the other. They drop the enable on the last data symbol, and they toggle the pin during idle clocks, which must have no effect. A sweep over all three modes then varies the enable source, the pin pattern and idle gaps. Expected symbols come from a modular-sum model kept in the bench.

// File: rtl/burst_diffenc_pkg.sv
package burst_diffenc_pkg;

   typedef enum logic [1:0] {
      MOD_BPSK  = 2'b00,
      MOD_QPSK  = 2'b01,
      MOD_QAM16 = 2'b10
   } mod_e;

   // 1x selects 16QAM, 01 QPSK, 00 BPSK
   function automatic mod_e decode_mod(input logic [1:0] sel);
      if (sel[1])
         return MOD_QAM16;
      else if (sel[0])
         return MOD_QPSK;
      return MOD_BPSK;
   endfunction

endpackage

// File: rtl/diffenc_enable_track.sv
module diffenc_enable_track (
   input  logic clk,
   input  logic rst_n,
   input  logic sym_valid_i,
   input  logic en_pin_i,
   input  logic en_reg_i,
   input  logic en_src_i,
   output logic enc_on_o
);

   logic en_now;
   logic en_hist_q;

   // R9: one select picks the enable source
   assign en_now = en_src_i ? en_reg_i : en_pin_i;

   // enable history advances only with accepted symbols (R3, R11)
   always_ff @(posedge clk) begin
      if (!rst_n)
         en_hist_q <= 1'b0;
      else if (sym_valid_i)
         en_hist_q <= en_now;
   end

   assign enc_on_o = en_hist_q;

   assert_hist_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sym_valid_i) |-> $stable(enc_on_o));

endmodule

// File: rtl/diffenc_phase_add.sv
module diffenc_phase_add
   import burst_diffenc_pkg::*;
#(
   parameter int SYM_W  = 4,
   parameter int DIFF_W = 2
) (
   input  mod_e              mode_i,
   input  logic [SYM_W-1:0]  sym_i,
   input  logic [DIFF_W-1:0] ref_i,
   input  logic              enc_on_i,
   output logic [SYM_W-1:0]  sym_o,
   output logic [DIFF_W-1:0] ref_o
);

   localparam int PASS_W = SYM_W - DIFF_W;

   logic [DIFF_W-1:0] base;
   logic [DIFF_W-1:0] low_sum;
   logic [DIFF_W-1:0] high_sum;
   logic              bit_sum;

   // an unencoded symbol is the same as an encoding against zero
   assign base     = enc_on_i ? ref_i : '0;
   assign bit_sum  = sym_i[0] ^ base[0];
   assign low_sum  = sym_i[DIFF_W-1:0] + base;
   assign high_sum = sym_i[SYM_W-1 -: DIFF_W] + base;

   always_comb begin
      sym_o = '0;
      ref_o = '0;
      unique case (mode_i)
         MOD_BPSK: begin
            sym_o[0] = bit_sum;
            ref_o[0] = bit_sum;
         end
         MOD_QPSK: begin
            sym_o[DIFF_W-1:0] = low_sum;
            ref_o             = low_sum;
         end
         default: begin
            sym_o[SYM_W-1 -: DIFF_W] = high_sum;
            sym_o[PASS_W-1:0]        = sym_i[PASS_W-1:0];
            ref_o                    = high_sum;
         end
      endcase
   end

endmodule

// File: rtl/burst_diff_encoder.sv
module burst_diff_encoder
   import burst_diffenc_pkg::*;
#(
   parameter int SYM_W   = 4,
   parameter int DIFF_W  = 2,
   parameter int REG_OUT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_valid_i,
   input  logic [SYM_W-1:0] sym_i,
   input  logic [1:0]       mod_sel_i,
   input  logic             en_pin_i,
   input  logic             en_reg_i,
   input  logic             en_src_i,
   output logic [SYM_W-1:0] sym_o,
   output logic             sym_valid_o
);

   generate
      if (DIFF_W < 1 || DIFF_W >= SYM_W) begin : g_bad_widths
         $error("DIFF_W must be at least 1 and below SYM_W");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_regout
         $error("REG_OUT must be 0 or 1");
      end
   endgenerate

   mod_e              mode;
   logic              enc_on;
   logic [SYM_W-1:0]  enc_sym;
   logic [DIFF_W-1:0] next_ref;
   logic [DIFF_W-1:0] ref_q;

   assign mode = decode_mod(mod_sel_i);

   diffenc_enable_track i_en (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_valid_i (sym_valid_i),
      .en_pin_i    (en_pin_i),
      .en_reg_i    (en_reg_i),
      .en_src_i    (en_src_i),
      .enc_on_o    (enc_on)
   );

   diffenc_phase_add #(
      .SYM_W  (SYM_W),
      .DIFF_W (DIFF_W)
   ) i_add (
      .mode_i   (mode),
      .sym_i    (sym_i),
      .ref_i    (ref_q),
      .enc_on_i (enc_on),
      .sym_o    (enc_sym),
      .ref_o    (next_ref)
   );

   // reference follows every sent symbol, encoded or not (R8)
   always_ff @(posedge clk) begin
      if (!rst_n)
         ref_q <= '0;
      else if (sym_valid_i)
         ref_q <= next_ref;
   end

   function automatic logic [DIFF_W-1:0] field_of(input logic [SYM_W-1:0] s, input mod_e m);
      logic [DIFF_W-1:0] f;
      f = '0;
      if (m == MOD_BPSK)      f[0] = s[0];
      else if (m == MOD_QPSK) f = s[DIFF_W-1:0];
      else                    f = s[SYM_W-1 -: DIFF_W];
      return f;
   endfunction

   function automatic logic [SYM_W-1:0] plain_of(input logic [SYM_W-1:0] s, input mod_e m);
      logic [SYM_W-1:0] p;
      p = '0;
      if (m == MOD_BPSK)      p[0] = s[0];
      else if (m == MOD_QPSK) p[DIFF_W-1:0] = s[DIFF_W-1:0];
      else                    p = s;
      return p;
   endfunction

   generate
      if (REG_OUT == 1) begin : g_reg_out
         logic [SYM_W-1:0] sym_q;
         logic             vld_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sym_q <= '0;
               vld_q <= 1'b0;
            end else begin
               vld_q <= sym_valid_i;
               if (sym_valid_i)
                  sym_q <= enc_sym;
            end
         end

         assign sym_o       = sym_q;
         assign sym_valid_o = vld_q;

         assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sym_valid_o == $past(sym_valid_i));

         assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(sym_valid_i) |-> $stable(sym_o));

         assert_plain_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sym_valid_i && !enc_on) |-> sym_o == plain_of($past(sym_i), $past(mode)));

         assert_ref_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sym_valid_o |-> ref_q == field_of(sym_o, $past(mode)));

         assert_bpsk_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sym_valid_o && $past(mode) == MOD_BPSK) |-> sym_o[SYM_W-1:1] == '0);
      end else begin : g_comb_out
         assign sym_o       = sym_valid_i ? enc_sym : '0;
         assign sym_valid_o = sym_valid_i;
      end
   endgenerate

endmodule

// File: tb/test_burst_diff_encoder.sv
`timescale 1ns/1ps
module test_burst_diff_encoder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sym_valid_i;
   logic [3:0] sym_i;
   logic [1:0] mod_sel_i;
   logic       en_pin_i, en_reg_i, en_src_i;
   logic [3:0] sym_o;
   logic       sym_valid_o;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   logic [1:0] m_ref  = 2'b00;
   logic       m_prev = 1'b0;
   logic [3:0] m_last = 4'h0;

   always #2.5 clk = ~clk;

   burst_diff_encoder i_burst_diff_encoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_valid_i (sym_valid_i),
      .sym_i       (sym_i),
      .mod_sel_i   (mod_sel_i),
      .en_pin_i    (en_pin_i),
      .en_reg_i    (en_reg_i),
      .en_src_i    (en_src_i),
      .sym_o       (sym_o),
      .sym_valid_o (sym_valid_o)
   );

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one symbol at a falling edge, check it one clock later
   task automatic send(input logic [3:0] s, input logic [1:0] md, input logic pin,
                       input logic rb, input logic src, input string tag);
      logic       en;
      logic [1:0] o2;
      logic [3:0] exp;
      logic [1:0] nref;
      sym_valid_i = 1'b1; sym_i = s; mod_sel_i = md;
      en_pin_i = pin; en_reg_i = rb; en_src_i = src;
      en = src ? rb : pin;
      if (md[1]) begin
         o2   = m_prev ? s[3:2] + m_ref : s[3:2];
         exp  = {o2, s[1:0]};
         nref = o2;
      end else if (md[0]) begin
         o2   = m_prev ? s[1:0] + m_ref : s[1:0];
         exp  = {2'b00, o2};
         nref = o2;
      end else begin
         o2   = {1'b0, m_prev ? (s[0] ^ m_ref[0]) : s[0]};
         exp  = {3'b000, o2[0]};
         nref = o2;
      end
      @(negedge clk);
      check({tag, " valid"}, {4'h0, sym_valid_o}, 5'h01);
      check(tag, {1'b0, sym_o}, {1'b0, exp});
      m_ref  = nref;
      m_prev = en;
      m_last = exp;
   endtask

   task automatic idle(input logic pin);
      sym_valid_i = 1'b0; en_pin_i = pin;
      @(negedge clk);
      check("R2 idle valid", {4'h0, sym_valid_o}, 5'h00);
      check("R11 idle hold", {1'b0, sym_o}, {1'b0, m_last});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sym_valid_i = 1'b0; sym_i = 4'h0; mod_sel_i = 2'b01;
      en_pin_i = 1'b0; en_reg_i = 1'b0; en_src_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset valid", {4'h0, sym_valid_o}, 5'h00);
      check("R1 reset sym", {1'b0, sym_o}, 5'h00);
      rst_n = 1'b1;
      // R1: first symbol after reset is unencoded even with enable high
      send(4'h3, 2'b01, 1'b1, 1'b0, 1'b0, "R1 first");
      send(4'h1, 2'b01, 1'b1, 1'b0, 1'b0, "R4 continue");

      // R7 normal timing: rise on last preamble symbol
      send(4'h2, 2'b01, 1'b0, 1'b0, 1'b0, "R3 preamble");
      send(4'h1, 2'b01, 1'b0, 1'b0, 1'b0, "R3 preamble");
      send(4'h2, 2'b01, 1'b1, 1'b0, 1'b0, "R8 last preamble");
      send(4'h1, 2'b01, 1'b1, 1'b0, 1'b0, "R7 first data vs preamble");
      send(4'h3, 2'b01, 1'b1, 1'b0, 1'b0, "R4 data");
      send(4'h1, 2'b01, 1'b0, 1'b0, 1'b0, "R10 last data encoded");
      send(4'h2, 2'b01, 1'b0, 1'b0, 1'b0, "R10 guard unencoded");

      // R7 late timing: rise on first data symbol (zero reference)
      send(4'h3, 2'b01, 1'b0, 1'b0, 1'b0, "R3 preamble");
      send(4'h1, 2'b01, 1'b1, 1'b0, 1'b0, "R7 zero reference");
      send(4'h2, 2'b01, 1'b1, 1'b0, 1'b0, "R8 after zero ref");

      // R9: software source, pin ignored
      send(4'h1, 2'b01, 1'b0, 1'b1, 1'b1, "R9 sw source");
      send(4'h3, 2'b01, 1'b0, 1'b1, 1'b1, "R9 sw encodes, pin low");
      send(4'h2, 2'b01, 1'b1, 1'b0, 1'b1, "R9 sw encodes");
      send(4'h1, 2'b01, 1'b1, 1'b0, 1'b1, "R9 pin high ignored");

      // R11: enable pulses only during idle clocks
      send(4'h2, 2'b01, 1'b0, 1'b0, 1'b0, "R3 before idle");
      idle(1'b1);
      idle(1'b1);
      send(4'h1, 2'b01, 1'b0, 1'b0, 1'b0, "R11 idle enable ignored");

      // sweep all modes, sources, enable patterns and idle gaps
      for (int md = 0; md < 4; md++) begin
         for (int i = 0; i < 48; i++) begin
            logic [3:0] s;
            logic pin, rb, src;
            string tag;
            s   = 4'((i * 5 + md * 3) & 15);
            pin = (i % 7) < 4;
            rb  = ((i / 3) % 2) == 0;
            src = ((i / 16) % 2) == 1;
            tag = (md == 0) ? "R5 bpsk" : (md == 1) ? "R4 qpsk" : "R6 qam16";
            send(s, 2'(md), pin, rb, src, tag);
            if (i % 9 == 8) idle(!pin);
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule